// File: doc/BRIEF.md
# Crypto Engine Command Queue Sequencer

This block sits between software and a block-cipher datapath. Software pushes 32-bit command words into a single queue-write register. A small in-order queue buffers them. A sequencer pops the words one at a time, decodes the opcode in the top six bits, and drives two request ports. One port goes to a cipher datapath that transforms one 16-byte block in place per handshake. The other goes to a memory reader that loads key material into a key slot.

Multi-word commands are supported: a DMA-setup command makes the next queued word the buffer address. A start command then walks that buffer block by block. Results go to a separately programmed destination address. A DMA-complete command closes the buffer session. Software watches busy, queue-empty and DMA-busy bits and a set of sticky error flags that are cleared by writing ones. While any error flag is pending, the sequencer holds the queue.

Top module: `cmdq_sequencer`

## Requirements
- R1: After reset the status register reads 0x0000_0008 (only queue-empty set), the queue-control and destination registers read 0, and neither request output is asserted.
- R2: A write to the queue register (index 0) is ignored unless bit 1 of the queue-control register (index 1) is set: the queue stays empty and no error flag is raised.
- R3: The queue holds 4 words. A write to the full queue is dropped and sets status bit 12.
- R4: The opcode is bits [31:26]. Opcode 0x10 (DMA setup) makes the next queued word the buffer base address instead of a command, and opens a buffer session.
- R5: Opcode 0x0e with bits [15:0] = N-1 issues N cipher requests one after another. Request i carries source = base + 16·i and destination = D + 16·i, where D is the destination register (index 3) when the command is decoded. Each request and its addresses are held until acknowledged.
- R6: Opcode 0x0e with no open buffer session sets status bit 14 and issues no cipher request.
- R7: Opcode 0x11 (DMA complete) closes the buffer session, so a later 0x0e without a new setup behaves as in R6.
- R8: Opcode 0x15 issues one table-load request with select = bits [25:24], slot id = bits [23:17] and key address = bits [16:0], held until acknowledged.
- R9: Any other opcode is discarded and sets status bit 13.
- R10: Status (index 2) bit 0 is set while a cipher or table command executes. Bit 23 is set while a cipher request is outstanding. Bit 3 is set while the queue is empty.
- R11: Error bits 12 to 14 are cleared by writing 1 to them; writing 0 leaves them. While any error bit is set, no queued word is decoded.
- R12: An idle sequencer with no pending error decodes a word on the clock edge after the one that stores it. When a clearing write and a new error fall on the same edge, the error stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 queue, 1 queue control, 2 status, 3 destination |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| blk_req | output | 1 | Cipher block request |
| blk_src | output | 32 | Source address of the current block |
| blk_dst | output | 32 | Destination address of the current block |
| blk_ack | input | 1 | Cipher block done |
| tbl_req | output | 1 | Key table load request |
| tbl_select | output | 2 | Table select field |
| tbl_id | output | 7 | Key-table slot id field |
| tbl_addr | output | 17 | Key material address |
| tbl_ack | input | 1 | Table load done |

## Verification
Two functions can meet on one clock edge. The sequencer can raise the bad-opcode flag on the same edge that a software clearing write lands on the status register. The bench provokes this by writing an unknown opcode into an empty, idle queue and writing all-ones to the error field in the very next cycle. Decode then coincides with the clear. The bench then reads status and requires bit 13 to still be set. Stalled-queue overflow, where the fifth word arrives while errors hold the queue, is judged the same way by reading the flag and the later drain.

// File: rtl/cq_pkg.sv
package cq_pkg;
   localparam int WORD_W      = 32;
   localparam int OPC_MSB     = 31;
   localparam int OPC_LSB     = 26;
   localparam int BLOCK_BYTES = 16;
   localparam int TBL_ADDR_W  = 17;
   localparam int TBL_ID_W    = 7;
   localparam int TBL_SEL_W   = 2;

   localparam logic [5:0] OPC_BLK_START = 6'h0e;
   localparam logic [5:0] OPC_DMA_SETUP = 6'h10;
   localparam logic [5:0] OPC_DMA_DONE  = 6'h11;
   localparam logic [5:0] OPC_SET_TABLE = 6'h15;

   localparam logic [1:0] RG_QUEUE  = 2'd0;
   localparam logic [1:0] RG_QCTL   = 2'd1;
   localparam logic [1:0] RG_STATUS = 2'd2;
   localparam logic [1:0] RG_DEST   = 2'd3;

   localparam int ST_BUSY   = 0;
   localparam int ST_EMPTY  = 3;
   localparam int ST_DMA    = 23;
   localparam int QCTL_EN   = 1;
   localparam int ERR_LSB   = 12;
   localparam int ERR_N     = 3;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_BLOCK,
      SQ_TABLE
   } sq_state_e;

   typedef struct packed {
      logic [TBL_SEL_W-1:0]  sel;
      logic [TBL_ID_W-1:0]   id;
      logic [TBL_ADDR_W-1:0] addr;
   } tbl_cmd_t;
endpackage

// File: rtl/cq_fifo.sv
module cq_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("cq_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] count;

   if ((1 << PW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   assign full  = (count == CNT_MAX);
   assign empty = (count == '0);
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push && !full) begin
         mem[wr_ptr] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push && !full) begin
            wr_ptr <= wr_nxt;
         end
         if (pop && !empty) begin
            rd_ptr <= rd_nxt;
         end
         case ({push && !full, pop && !empty})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/cq_errflags.sv
module cq_errflags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_wr,
   input  logic [N-1:0] clr_bits,
   input  logic [N-1:0] set_bits,
   output logic [N-1:0] flags,
   output logic         pending
);
   if (N < 1) begin : g_bad_n
      $error("cq_errflags: N must be positive");
   end

   logic [N-1:0] clr_mask;

   assign clr_mask = clr_wr ? clr_bits : '0;
   assign pending  = |flags;

   // a fresh error wins over a clear on the same edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= '0;
      end else begin
         flags <= (flags & ~clr_mask) | set_bits;
      end
   end
endmodule

// File: rtl/cq_seq.sv
module cq_seq
   import cq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] head,
   input  logic              avail,
   input  logic              stall,
   output logic              pop,
   input  logic [ADDR_W-1:0] dest_base,
   output logic              blk_req,
   output logic [ADDR_W-1:0] blk_src,
   output logic [ADDR_W-1:0] blk_dst,
   input  logic              blk_ack,
   output logic              tbl_req,
   output tbl_cmd_t          tbl_cmd,
   input  logic              tbl_ack,
   output logic              err_opc,
   output logic              err_nodma,
   output logic              busy,
   output logic              dma_busy
);
   localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(BLOCK_BYTES);

   sq_state_e         state;
   logic              expect_addr;
   logic              dma_open;
   logic [ADDR_W-1:0] dma_base;
   logic [ADDR_W-1:0] dst_base;
   logic [ADDR_W-1:0] offset;
   logic [CNT_W-1:0]  blk_left;
   logic [5:0]        opc;
   logic              opc_known;
   logic              is_cmd;

   assign opc       = head[OPC_MSB:OPC_LSB];
   assign pop       = (state == SQ_IDLE) && avail && !stall;
   assign is_cmd    = pop && !expect_addr;
   assign opc_known = (opc == OPC_BLK_START) || (opc == OPC_DMA_SETUP) ||
                      (opc == OPC_DMA_DONE)  || (opc == OPC_SET_TABLE);
   assign err_opc   = is_cmd && !opc_known;
   assign err_nodma = is_cmd && (opc == OPC_BLK_START) && !dma_open;

   assign blk_req  = (state == SQ_BLOCK);
   assign blk_src  = dma_base + offset;
   assign blk_dst  = dst_base + offset;
   assign tbl_req  = (state == SQ_TABLE);
   assign busy     = (state != SQ_IDLE);
   assign dma_busy = (state == SQ_BLOCK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= SQ_IDLE;
         expect_addr <= 1'b0;
         dma_open    <= 1'b0;
         dma_base    <= '0;
         dst_base    <= '0;
         offset      <= '0;
         blk_left    <= '0;
         tbl_cmd     <= '0;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (pop && expect_addr) begin
                  dma_base    <= head[ADDR_W-1:0];
                  dma_open    <= 1'b1;
                  expect_addr <= 1'b0;
               end else if (is_cmd) begin
                  case (opc)
                     OPC_DMA_SETUP: expect_addr <= 1'b1;
                     OPC_DMA_DONE:  dma_open    <= 1'b0;
                     OPC_BLK_START: begin
                        if (dma_open) begin
                           blk_left <= head[CNT_W-1:0];
                           offset   <= '0;
                           dst_base <= dest_base;
                           state    <= SQ_BLOCK;
                        end
                     end
                     OPC_SET_TABLE: begin
                        tbl_cmd <= head[$bits(tbl_cmd_t)-1:0];
                        state   <= SQ_TABLE;
                     end
                     default: ;
                  endcase
               end
            end
            SQ_BLOCK: begin
               if (blk_ack) begin
                  if (blk_left == '0) begin
                     state <= SQ_IDLE;
                  end else begin
                     blk_left <= blk_left - 1'b1;
                     offset   <= offset + STRIDE;
                  end
               end
            end
            SQ_TABLE: begin
               if (tbl_ack) begin
                  state <= SQ_IDLE;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cmdq_sequencer.sv
module cmdq_sequencer
   import cq_pkg::*;
#(
   parameter int QDEPTH = 4,
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [1:0]            reg_addr,
   input  logic [WORD_W-1:0]     reg_wdata,
   output logic [WORD_W-1:0]     reg_rdata,
   output logic                  blk_req,
   output logic [ADDR_W-1:0]     blk_src,
   output logic [ADDR_W-1:0]     blk_dst,
   input  logic                  blk_ack,
   output logic                  tbl_req,
   output logic [TBL_SEL_W-1:0]  tbl_select,
   output logic [TBL_ID_W-1:0]   tbl_id,
   output logic [TBL_ADDR_W-1:0] tbl_addr,
   input  logic                  tbl_ack
);
   if (ADDR_W < TBL_ADDR_W || ADDR_W > WORD_W) begin : g_bad_aw
      $error("cmdq_sequencer: ADDR_W out of range");
   end
   if (CNT_W < 1 || CNT_W > OPC_LSB) begin : g_bad_cw
      $error("cmdq_sequencer: CNT_W out of range");
   end

   logic              qctl_en;
   logic [ADDR_W-1:0] dest_q;
   logic              q_attempt, q_push, q_pop, q_full, q_empty;
   logic [WORD_W-1:0] q_head;
   logic [ERR_N-1:0]  err_set, err_q;
   logic              err_pend, err_opc, err_nodma, err_full;
   logic              busy, dma_busy, stat_clr;
   logic [WORD_W-1:0] stat_word;
   tbl_cmd_t          tbl_cmd;

   assign q_attempt = reg_wr && (reg_addr == RG_QUEUE);
   assign q_push    = q_attempt && qctl_en;
   assign err_full  = q_push && q_full;
   assign stat_clr  = reg_wr && (reg_addr == RG_STATUS);
   assign err_set   = {err_nodma, err_opc, err_full};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         qctl_en <= 1'b0;
         dest_q  <= '0;
      end else if (reg_wr) begin
         if (reg_addr == RG_QCTL) begin
            qctl_en <= reg_wdata[QCTL_EN];
         end
         if (reg_addr == RG_DEST) begin
            dest_q <= reg_wdata[ADDR_W-1:0];
         end
      end
   end

   cq_fifo #(.DEPTH(QDEPTH), .W(WORD_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push),
      .din   (reg_wdata),
      .pop   (q_pop),
      .dout  (q_head),
      .full  (q_full),
      .empty (q_empty)
   );

   cq_errflags #(.N(ERR_N)) u_err (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_wr   (stat_clr),
      .clr_bits (reg_wdata[ERR_LSB +: ERR_N]),
      .set_bits (err_set),
      .flags    (err_q),
      .pending  (err_pend)
   );

   cq_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .head      (q_head),
      .avail     (!q_empty),
      .stall     (err_pend),
      .pop       (q_pop),
      .dest_base (dest_q),
      .blk_req   (blk_req),
      .blk_src   (blk_src),
      .blk_dst   (blk_dst),
      .blk_ack   (blk_ack),
      .tbl_req   (tbl_req),
      .tbl_cmd   (tbl_cmd),
      .tbl_ack   (tbl_ack),
      .err_opc   (err_opc),
      .err_nodma (err_nodma),
      .busy      (busy),
      .dma_busy  (dma_busy)
   );

   assign tbl_select = tbl_cmd.sel;
   assign tbl_id     = tbl_cmd.id;
   assign tbl_addr   = tbl_cmd.addr;

   always_comb begin
      stat_word                       = '0;
      stat_word[ST_BUSY]              = busy;
      stat_word[ST_EMPTY]             = q_empty;
      stat_word[ST_DMA]               = dma_busy;
      stat_word[ERR_LSB +: ERR_N]     = err_q;
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RG_QCTL:   reg_rdata[QCTL_EN] = qctl_en;
         RG_STATUS: reg_rdata = stat_word;
         RG_DEST:   reg_rdata[ADDR_W-1:0] = dest_q;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/cmdq_sequencer_chk.sv
module cmdq_sequencer_chk
   import cq_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              q_attempt,
   input logic              qctl_en,
   input logic              q_full,
   input logic              q_empty,
   input logic              q_pop,
   input logic              err_pend,
   input logic [ERR_N-1:0]  err_q,
   input logic              blk_req,
   input logic              blk_ack,
   input logic [ADDR_W-1:0] blk_src,
   input logic [ADDR_W-1:0] blk_dst,
   input logic              tbl_req,
   input logic              tbl_ack,
   input logic [TBL_ADDR_W-1:0] tbl_addr,
   input logic [WORD_W-1:0] stat_word
);
   p_disabled_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (q_attempt && !qctl_en && q_empty) |=> q_empty);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (q_attempt && qctl_en && q_full) |=> err_q[0]);

   p_blk_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_req && !blk_ack) |=> (blk_req && $stable(blk_src) && $stable(blk_dst)));

   p_tbl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_req && !tbl_ack) |=> (tbl_req && $stable(tbl_addr)));

   p_one_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(blk_req && tbl_req));

   p_dma_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
      blk_req |-> (stat_word[ST_DMA] && stat_word[ST_BUSY]));

   p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
      err_pend |-> !q_pop);
endmodule

bind cmdq_sequencer cmdq_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .q_attempt (q_attempt),
   .qctl_en   (qctl_en),
   .q_full    (q_full),
   .q_empty   (q_empty),
   .q_pop     (q_pop),
   .err_pend  (err_pend),
   .err_q     (err_q),
   .blk_req   (blk_req),
   .blk_ack   (blk_ack),
   .blk_src   (blk_src),
   .blk_dst   (blk_dst),
   .tbl_req   (tbl_req),
   .tbl_ack   (tbl_ack),
   .tbl_addr  (tbl_addr),
   .stat_word (stat_word)
);

// File: tb/tb_cmdq_sequencer.sv
module tb_cmdq_sequencer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] reg_rdata;
   logic        blk_req, tbl_req;
   logic [31:0] blk_src, blk_dst;
   logic        blk_ack = 1'b0, tbl_ack = 1'b0;
   logic [1:0]  tbl_select;
   logic [6:0]  tbl_id;
   logic [16:0] tbl_addr;

   localparam logic [1:0] A_Q = 2'd0, A_CTL = 2'd1, A_ST = 2'd2, A_DST = 2'd3;
   localparam logic [31:0] EMASK = 32'h006f_f000;

   int nchk = 0, nerr = 0, lat_cfg = 0, nblk = 0, ntbl = 0, bcnt = 0, tcnt = 0;
   bit done = 0;
   logic [31:0] rec_src [64];
   logic [31:0] rec_dst [64];
   logic [1:0]  rec_sel;
   logic [6:0]  rec_id;
   logic [16:0] rec_addr;

   cmdq_sequencer dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .blk_req(blk_req), .blk_src(blk_src), .blk_dst(blk_dst), .blk_ack(blk_ack),
      .tbl_req(tbl_req), .tbl_select(tbl_select), .tbl_id(tbl_id),
      .tbl_addr(tbl_addr), .tbl_ack(tbl_ack)
   );

   always #2 clk = ~clk;

   // cipher and table-load stand-ins
   always @(negedge clk) begin
      if (!rst_n) begin
         blk_ack <= 1'b0; tbl_ack <= 1'b0; bcnt = 0; tcnt = 0;
      end else begin
         if (blk_ack) blk_ack <= 1'b0;
         else if (blk_req) begin
            if (bcnt >= lat_cfg) begin
               blk_ack <= 1'b1; bcnt = 0;
               if (nblk < 64) begin rec_src[nblk] = blk_src; rec_dst[nblk] = blk_dst; end
               nblk++;
            end else bcnt++;
         end
         if (tbl_ack) tbl_ack <= 1'b0;
         else if (tbl_req) begin
            if (tcnt >= lat_cfg) begin
               tbl_ack <= 1'b1; tcnt = 0;
               rec_sel = tbl_select; rec_id = tbl_id; rec_addr = tbl_addr;
               ntbl++;
            end else tcnt++;
         end
      end
   end

   function automatic logic [31:0] mk(input logic [5:0] op, input logic [25:0] low);
      return {op, low};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      int g = 0;
      rd(A_ST, s);
      while (((s[0] != 1'b0) || (s[3] != 1'b1)) && g < 3000) begin
         rd(A_ST, s); g++;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   endtask

   task automatic xfer(input logic [31:0] base, input logic [31:0] dst, input int n);
      logic [31:0] s;
      wr(A_DST, dst);
      nblk = 0;
      wr(A_Q, mk(6'h10, 26'd0));
      wr(A_Q, base);
      wr(A_Q, mk(6'h0e, 26'(n - 1)));
      wr(A_Q, mk(6'h11, 26'd0));
      wait_idle();
      chk("R5 block count", 32'(nblk), 32'(n));
      for (int i = 0; i < n && i < 64; i++) begin
         chk("R4 R5 block source", rec_src[i], base + 32'(16 * i));
         chk("R5 block destination", rec_dst[i], dst + 32'(16 * i));
      end
      rd(A_ST, s);
      chk("R10 status idle after transfer", s, 32'h8);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      finish_run();
   end

   initial begin
      logic [31:0] s;
      void'($urandom(32'h5eed_c0de));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_ST, s);  chk("R1 status", s, 32'h8);
      rd(A_CTL, s); chk("R1 qctl", s, 32'h0);
      rd(A_DST, s); chk("R1 dest", s, 32'h0);
      chk("R1 requests idle", {30'd0, blk_req, tbl_req}, 32'h0);

      // R2 queue disabled
      wr(A_Q, mk(6'h3f, 26'd0));
      rd(A_ST, s); chk("R2 disabled write ignored", s, 32'h8);
      wr(A_CTL, 32'h2);
      rd(A_CTL, s); chk("R2 enable readback", s, 32'h2);
      rd(A_ST, s); chk("R2 nothing left queued", s, 32'h8);

      // R6 start without setup
      nblk = 0;
      wr(A_Q, mk(6'h0e, 26'd0));
      wait_idle();
      rd(A_ST, s); chk("R6 no-session error", s, 32'h4008);
      chk("R6 no cipher request", 32'(nblk), 32'd0);
      wr(A_ST, 32'h4000);
      rd(A_ST, s); chk("R11 clear bit 14", s, 32'h8);

      // R12 and R9: decode on the same edge as a clearing write
      wr(A_Q, mk(6'h3f, 26'd0));
      wr(A_ST, EMASK);
      rd(A_ST, s); chk("R12 R9 error survives same-edge clear", s, 32'h2008);

      // R11 stall, R3 overflow while stalled
      nblk = 0;
      wr(A_DST, 32'h0000_8000);
      wr(A_Q, mk(6'h10, 26'd0));
      wr(A_Q, 32'h0000_1000);
      wr(A_Q, mk(6'h0e, 26'd0));
      wr(A_Q, mk(6'h11, 26'd0));
      wr(A_Q, mk(6'h3f, 26'd0));
      rd(A_ST, s); chk("R3 R11 full queue held, overflow flag", s, 32'h3000);
      chk("R11 nothing decoded while pending", 32'(nblk), 32'd0);
      wr(A_ST, 32'h0);
      rd(A_ST, s); chk("R11 zero write keeps flags", s, 32'h3000);
      wr(A_ST, 32'h3000);
      wait_idle();
      chk("R3 four stored words ran", 32'(nblk), 32'd1);
      chk("R4 address word", rec_src[0], 32'h0000_1000);
      chk("R5 destination", rec_dst[0], 32'h0000_8000);
      rd(A_ST, s); chk("R3 no extra word decoded", s, 32'h8);

      // R7 session closed
      wr(A_Q, mk(6'h0e, 26'd0));
      wait_idle();
      rd(A_ST, s); chk("R7 start after complete", s, 32'h4008);
      wr(A_ST, EMASK);

      // R10 busy bits during a slow run
      lat_cfg = 6; nblk = 0;
      wr(A_DST, 32'h0000_4000);
      wr(A_Q, mk(6'h10, 26'd0));
      wr(A_Q, 32'h0000_2000);
      wr(A_Q, mk(6'h0e, 26'd2));
      @(negedge clk); @(negedge clk);
      rd(A_ST, s); chk("R10 busy and dma bits", s & 32'h0080_0001, 32'h0080_0001);
      wr(A_Q, mk(6'h11, 26'd0));
      wait_idle();
      chk("R5 three blocks", 32'(nblk), 32'd3);
      chk("R5 last source", rec_src[2], 32'h0000_2020);
      chk("R5 last destination", rec_dst[2], 32'h0000_4020);

      // R8 table load
      ntbl = 0;
      wr(A_Q, mk(6'h15, {2'd3, 7'h0a, 17'h1_2340}));
      @(negedge clk);
      rd(A_ST, s); chk("R10 table busy without dma bit", s & 32'h0080_0001, 32'h1);
      wait_idle();
      chk("R8 one table request", 32'(ntbl), 32'd1);
      chk("R8 select", 32'(rec_sel), 32'd3);
      chk("R8 slot id", 32'(rec_id), 32'h0a);
      chk("R8 address", 32'(rec_addr), 32'h1_2340);

      // random mix
      for (int it = 0; it < 30; it++) begin
         int kind;
         kind = int'($urandom % 3);
         lat_cfg = int'($urandom % 4);
         if (kind == 0) begin
            xfer($urandom & 32'hffff_fff0, $urandom & 32'hffff_fff0, 1 + int'($urandom % 6));
         end else if (kind == 1) begin
            logic [25:0] f;
            f = 26'($urandom);
            ntbl = 0;
            wr(A_Q, mk(6'h15, f));
            wait_idle();
            chk("R8 random table count", 32'(ntbl), 32'd1);
            chk("R8 random table fields", {6'd0, rec_sel, rec_id, rec_addr}, {6'd0, f});
         end else begin
            logic [5:0] op;
            op = 6'($urandom);
            while (op == 6'h0e || op == 6'h10 || op == 6'h11 || op == 6'h15) op = 6'($urandom);
            wr(A_Q, mk(op, 26'($urandom)));
            wait_idle();
            rd(A_ST, s); chk("R9 unknown opcode flagged", s, 32'h2008);
            wr(A_ST, 32'h2000);
            rd(A_ST, s); chk("R11 cleared", s, 32'h8);
         end
      end

      finish_run();
   end
endmodule